// File: doc/BRIEF.md
# Subcarrier Manchester Response Encoder

This block turns a byte stream into the load-modulation enable line of a contactless tag's reply. It runs on the 13.56 MHz carrier clock, so one clock cycle is one carrier period. Each data bit is Manchester coded. Every half-bit is either a burst of subcarrier pulses or a gap. The subcarriers are derived from the carrier by division: fc/32 by default, plus fc/28 when two subcarriers are in use. A reply opens with a start-of-frame pattern and closes with an end-of-frame pattern.

The mode inputs are sampled when a frame starts. They choose low or high data rate, one or two subcarriers, and a fast mode that halves every pulse count. Bytes are delivered with valid/ready into a single holding register, so the source has one whole byte time to supply the next byte. The frame ends after the last byte for which data is present at a byte boundary. A request for fast mode together with two subcarriers is rejected.

Top module: `sc_resp_encoder`

## Requirements
- R1: After reset and whenever no frame is in progress, mod_o, busy_o, byte_ready_o and err_o are all 0.
- R2: A subcarrier pulse of divider D (SC1_DIV for the first subcarrier, SC2_DIV for the second) drives mod_o high for D/2 cycles and then low for D/2 cycles. A gap on one subcarrier holds mod_o low.
- R3: Let the half-bit unit count be h. At the high rate with no fast mode, h = HALF_PULSES = 8. A logic 0 is h first-subcarrier pulses followed by a gap. A logic 1 is a gap followed by h pulses. A gap of u units lasts u*SC1_DIV cycles. Bits of each byte go out least significant bit first.
- R4: The start of frame is a gap of 3h units, then 3h pulses, then a logic 1. The end of frame is a logic 0, then 3h pulses, then a gap of 3h units. The multiplier 3 is SOF_MULT.
- R5: At the low rate, h is multiplied by 2^LOW_SHIFT = 4 everywhere, including the start and end of frame.
- R6: With two subcarriers, every gap of u units is replaced by a burst of u*9/8 pulses at SC2_DIV. Bursts of the first subcarrier are unchanged.
- R7: In fast mode (one subcarrier only), h is halved at either rate.
- R8: At each byte boundary, if no byte is held and byte_valid_i is low, the end of frame follows directly. A frame with no bytes is a start of frame followed at once by an end of frame.
- R9: If start_i arrives while idle with fast_i=1 and dual_sc_i=1, err_o pulses high for exactly one cycle. No frame starts and mod_o stays 0.
- R10: start_i and the mode inputs are ignored while busy_o is 1. The modes that apply are the ones sampled when the frame started.
- R11: The waveform begins in the cycle after start_i is accepted and runs without pause. busy_o is 1 from that cycle through the last waveform cycle and drops in the cycle after it.
- R12: byte_ready_o is 1 during the start of frame and during data while the holding register is empty. A byte transfers when byte_valid_i and byte_ready_o are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request |
| low_rate_i | input | 1 | 1 selects the low data rate |
| dual_sc_i | input | 1 | 1 selects two subcarriers |
| fast_i | input | 1 | 1 selects the halved-count fast mode |
| byte_i | input | 8 | Data byte |
| byte_valid_i | input | 1 | Data byte valid |
| byte_ready_o | output | 1 | Holding register can take a byte |
| mod_o | output | 1 | Load modulation enable |
| busy_o | output | 1 | Frame in progress |
| err_o | output | 1 | One-cycle pulse on a rejected mode request |

## Verification
The bench builds the encoder with SC1_DIV=4 and SC2_DIV=6. HALF_PULSES, SOF_MULT and LOW_SHIFT keep their defaults, so the pulse counts are the real ones and only the pulse periods shrink. The short dividers make low-rate frames cheap, so every rate, subcarrier and fast-mode combination can be compared cycle by cycle within the run. The unequal dividers ensure that a second-subcarrier gap cannot be mistaken for a first-subcarrier burst.

// File: rtl/sc_resp_pkg.sv
package sc_resp_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SOF, PH_DATA, PH_EOF} phase_e;

  typedef struct packed {
    logic low_rate;
    logic dual_sc;
    logic fast;
  } mode_t;
endpackage

// File: rtl/sc_tone_gen.sv
module sc_tone_gen #(
  parameter int SC1_DIV = 32,
  parameter int SC2_DIV = 28,
  parameter int UW      = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          burst_i,
  input  logic          dual_i,
  input  logic [UW-1:0] units_i,
  output logic          mod_o,
  output logic          last_o
);
  localparam int MAXD = (SC1_DIV > SC2_DIV) ? SC1_DIV : SC2_DIV;
  localparam int CW   = $clog2(MAXD);
  localparam int PW   = UW + 1;

  logic [CW-1:0] cyc_q, div_m1, half;
  logic [PW-1:0] pul_q, npulse_m1;
  logic          is_sc2, wrap;

  always_comb begin
    is_sc2 = !burst_i && dual_i;
    div_m1 = is_sc2 ? CW'(SC2_DIV - 1) : CW'(SC1_DIV - 1);
    half   = is_sc2 ? CW'(SC2_DIV / 2) : CW'(SC1_DIV / 2);
    // second subcarrier fills a gap with 9 pulses per 8 units
    npulse_m1 = (is_sc2 ? ({1'b0, units_i} + PW'(units_i >> 3)) : {1'b0, units_i}) - PW'(1);
    wrap   = (cyc_q == div_m1);
    last_o = active_i && wrap && (pul_q == npulse_m1);
    mod_o  = active_i && (burst_i || dual_i) && (cyc_q < half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      pul_q <= '0;
    end else if (!active_i || last_o) begin
      cyc_q <= '0;
      pul_q <= '0;
    end else if (wrap) begin
      cyc_q <= '0;
      pul_q <= pul_q + PW'(1);
    end else begin
      cyc_q <= cyc_q + CW'(1);
    end
  end
endmodule

// File: rtl/sc_frame_seq.sv
module sc_frame_seq
  import sc_resp_pkg::*;
#(
  parameter int HALF_PULSES = 8,
  parameter int SOF_MULT    = 3,
  parameter int LOW_SHIFT   = 2,
  parameter int UW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  mode_t         mode_i,
  input  logic          elem_last_i,
  input  logic [7:0]    byte_i,
  input  logic          byte_valid_i,
  output logic          byte_ready_o,
  output logic          busy_o,
  output logic          err_o,
  output logic          active_o,
  output logic          burst_o,
  output logic          dual_o,
  output logic [UW-1:0] units_o
);
  phase_e        ph_q;
  logic [1:0]    step_q;
  logic [7:0]    sh_q, hb_q;
  logic [2:0]    bi_q;
  logic          hv_q, err_q;
  mode_t         mode_q;
  logic [UW-1:0] h_u, long_u;
  logic          mode_bad, accept, bnd, take;

  always_comb begin
    mode_bad = mode_i.fast && mode_i.dual_sc;
    accept   = (ph_q == PH_IDLE) && start_i && !mode_bad;
    h_u = UW'(HALF_PULSES);
    if (mode_q.low_rate) h_u = h_u << LOW_SHIFT;
    if (mode_q.fast)     h_u = h_u >> 1;
    long_u = h_u * UW'(SOF_MULT);
    byte_ready_o = ((ph_q == PH_SOF) || (ph_q == PH_DATA)) && !hv_q;
    take = byte_valid_i && byte_ready_o;
    bnd  = elem_last_i && (((ph_q == PH_SOF) && (step_q == 2'd3)) ||
                           ((ph_q == PH_DATA) && (step_q == 2'd1) && (bi_q == 3'd7)));
    busy_o   = (ph_q != PH_IDLE);
    active_o = busy_o;
    dual_o   = mode_q.dual_sc;
    err_o    = err_q;
    burst_o  = 1'b0;
    units_o  = h_u;
    case (ph_q)
      PH_SOF: begin
        burst_o = step_q[0];
        units_o = step_q[1] ? h_u : long_u;
      end
      PH_DATA: burst_o = (step_q == 2'd0) ? !sh_q[0] : sh_q[0];
      PH_EOF: begin
        burst_o = !step_q[0];
        units_o = step_q[1] ? long_u : h_u;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      step_q <= '0;
      sh_q   <= '0;
      hb_q   <= '0;
      bi_q   <= '0;
      hv_q   <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      err_q <= (ph_q == PH_IDLE) && start_i && mode_bad;
      if (accept) begin
        ph_q   <= PH_SOF;
        step_q <= '0;
        mode_q <= mode_i;
        hv_q   <= 1'b0;
      end else if (bnd) begin
        step_q <= '0;
        bi_q   <= '0;
        if (hv_q) begin
          sh_q <= hb_q;
          hv_q <= 1'b0;
          ph_q <= PH_DATA;
        end else if (byte_valid_i) begin
          sh_q <= byte_i;
          ph_q <= PH_DATA;
        end else begin
          ph_q <= PH_EOF;
        end
      end else begin
        if (take) begin
          hb_q <= byte_i;
          hv_q <= 1'b1;
        end
        if (elem_last_i) begin
          case (ph_q)
            PH_SOF: step_q <= step_q + 2'd1;
            PH_DATA: begin
              if (step_q == 2'd0) step_q <= 2'd1;
              else begin
                step_q <= 2'd0;
                sh_q   <= sh_q >> 1;
                bi_q   <= bi_q + 3'd1;
              end
            end
            PH_EOF: begin
              if (step_q == 2'd3) ph_q <= PH_IDLE;
              step_q <= step_q + 2'd1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sc_resp_encoder.sv
module sc_resp_encoder
  import sc_resp_pkg::*;
#(
  parameter int SC1_DIV     = 32,
  parameter int SC2_DIV     = 28,
  parameter int HALF_PULSES = 8,
  parameter int SOF_MULT    = 3,
  parameter int LOW_SHIFT   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       low_rate_i,
  input  logic       dual_sc_i,
  input  logic       fast_i,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  output logic       byte_ready_o,
  output logic       mod_o,
  output logic       busy_o,
  output logic       err_o
);
  localparam int UW = $clog2(HALF_PULSES * SOF_MULT * (1 << LOW_SHIFT)) + 2;

  mode_t         mode;
  logic          active, burst, dual, elem_last;
  logic [UW-1:0] units;

  always_comb begin
    mode.low_rate = low_rate_i;
    mode.dual_sc  = dual_sc_i;
    mode.fast     = fast_i;
  end

  sc_frame_seq #(
    .HALF_PULSES(HALF_PULSES), .SOF_MULT(SOF_MULT), .LOW_SHIFT(LOW_SHIFT), .UW(UW)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode),
    .elem_last_i(elem_last), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .busy_o(busy_o), .err_o(err_o),
    .active_o(active), .burst_o(burst), .dual_o(dual), .units_o(units)
  );

  sc_tone_gen #(
    .SC1_DIV(SC1_DIV), .SC2_DIV(SC2_DIV), .UW(UW)
  ) u_tone (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .burst_i(burst),
    .dual_i(dual), .units_i(units), .mod_o(mod_o), .last_o(elem_last)
  );
endmodule

// File: rtl/sc_resp_encoder_chk.sv
module sc_resp_encoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic dual_sc_i,
  input logic fast_i,
  input logic byte_ready_o,
  input logic mod_o,
  input logic busy_o,
  input logic err_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mod_o); // R1
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_o) |=> mod_o); // R2
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o); // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R9
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !(fast_i && dual_sc_i)) |=> busy_o); // R11
  AST_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> busy_o); // R12
endmodule

bind sc_resp_encoder sc_resp_encoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dual_sc_i(dual_sc_i),
  .fast_i(fast_i), .byte_ready_o(byte_ready_o), .mod_o(mod_o),
  .busy_o(busy_o), .err_o(err_o)
);

// File: tb/tb_sc_resp_encoder.sv
module tb_sc_resp_encoder;
  localparam int SC1 = 4;
  localparam int SC2 = 6;
  localparam int HP  = 8;
  localparam int SM  = 3;
  localparam int LS  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, low = 1'b0, dual = 1'b0, fast = 1'b0;
  logic [7:0] bdata = '0;
  logic bvalid = 1'b0;
  logic bready, mod, busy, err;

  always #5 clk = ~clk;

  sc_resp_encoder #(.SC1_DIV(SC1), .SC2_DIV(SC2), .HALF_PULSES(HP),
                    .SOF_MULT(SM), .LOW_SHIFT(LS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .low_rate_i(low),
    .dual_sc_i(dual), .fast_i(fast), .byte_i(bdata), .byte_valid_i(bvalid),
    .byte_ready_o(bready), .mod_o(mod), .busy_o(busy), .err_o(err)
  );

  int total = 0, bad = 0;
  bit exp_q[$];
  int mism = 0, first_bad = -1, seen = 0, idle_bad = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pop expected modulation per busy cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (exp_q.size() == 0) mism++;
        else if (exp_q.pop_front() != mod) begin
          if (first_bad < 0) first_bad = seen;
          mism++;
        end
        seen++;
      end else if (mod) idle_bad++;
    end
  end

  task automatic push_burst(int n, int d);
    for (int i = 0; i < n; i++)
      for (int c = 0; c < d; c++) exp_q.push_back(c < d / 2);
  endtask

  task automatic push_gap(int u, bit two);
    if (two) push_burst((u * 9) / 8, SC2);
    else for (int i = 0; i < u * SC1; i++) exp_q.push_back(1'b0);
  endtask

  task automatic push_bit(bit b, int h, bit two);
    if (!b) begin push_burst(h, SC1); push_gap(h, two); end
    else begin push_gap(h, two); push_burst(h, SC1); end
  endtask

  task automatic run_frame(string req, bit l, bit d, bit f, logic [7:0] bytes[$], bit poke);
    int h, elen;
    h = HP;
    if (l) h = h * (1 << LS);
    if (f) h = h / 2;
    exp_q.delete();
    push_gap(SM * h, d); push_burst(SM * h, SC1); push_bit(1'b1, h, d);
    foreach (bytes[i])
      for (int k = 0; k < 8; k++) push_bit(bytes[i][k], h, d);
    push_bit(1'b0, h, d); push_burst(SM * h, SC1); push_gap(SM * h, d);
    elen = exp_q.size();
    mism = 0; first_bad = -1; seen = 0;
    @(negedge clk);
    low = l; dual = d; fast = f; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < bytes.size(); i++) begin
      bvalid = 1'b1; bdata = bytes[i];
      while (!bready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      if (i == 0 && bytes.size() > 1)
        check(bready == 1'b0, "R12", "ready with byte held", int'(bready), 0);
    end
    bvalid = 1'b0;
    if (poke) begin
      check(busy == 1'b1, "R10", "busy before poke", int'(busy), 1);
      low = ~l; dual = 1'b0; fast = 1'b1; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    check(mism == 0, req, "waveform mismatches (first index in act)", first_bad, -1);
    check(seen == elen, req, "frame length", seen, elen);
    low = 1'b0; dual = 1'b0; fast = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, mod, bready, err} == 4'b0, "R1", "reset outputs", int'({busy, mod, bready, err}), 0);

    q = '{8'hA5, 8'h3C};
    run_frame("R2 R3 R4 R11", 1'b0, 1'b0, 1'b0, q, 1'b0);
    q = '{8'h96};
    run_frame("R5", 1'b1, 1'b0, 1'b0, q, 1'b0);
    q = '{8'h5A, 8'h01};
    run_frame("R6 high", 1'b0, 1'b1, 1'b0, q, 1'b0);
    q = '{8'hC3};
    run_frame("R6 low", 1'b1, 1'b1, 1'b0, q, 1'b0);
    q = '{8'hF0};
    run_frame("R7 high", 1'b0, 1'b0, 1'b1, q, 1'b0);
    q = '{8'h0F};
    run_frame("R7 low", 1'b1, 1'b0, 1'b1, q, 1'b0);
    q = {};
    run_frame("R8", 1'b0, 1'b0, 1'b0, q, 1'b0);
    q = '{8'h81};
    run_frame("R10", 1'b0, 1'b0, 1'b0, q, 1'b1);

    @(negedge clk);
    fast = 1'b1; dual = 1'b1; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, "R9", "err pulse", int'(err), 1);
    check(busy == 1'b0, "R9", "no frame on bad mode", int'(busy), 0);
    @(negedge clk);
    check({err, busy, mod} == 3'b0, "R9", "err cleared, quiet", int'({err, busy, mod}), 0);
    fast = 1'b0; dual = 1'b0;
    repeat (5) @(negedge clk);
    check(idle_bad == 0, "R1", "modulation while idle", idle_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule